// File: doc/BRIEF.md
# Dual-Bank Maskable Interrupt Controller

This block collects interrupt events for a secondary processor and turns them into one level-sensitive request vector. It keeps two enable/flag register pairs. The main pair is 32 bits wide. The auxiliary pair is 16 bits wide and serves a separate group of peripheral sources: three lines of one GPIO group, four lines of a second GPIO group (including headphone detect and the power button), SD/MMC and SDIO events, the AES engine, I2C and an external microphone. A single master enable bit gates the combined request.

Peripherals raise and drop individual flag bits through per-source set and clear strobes. Software reads and writes all registers over a simple register bus with per-byte write strobes, so 16-bit and 32-bit accesses are both supported. A flag-register write clears each bit written with 1. The parameter `HAS_AUX` builds the auxiliary pair only for the processor that owns those sources. The other processor's instance uses the main pair alone.

Register offsets within the window (word aligned, address bits 1:0 ignored): master 0x208, main enable 0x210, main flags 0x214, auxiliary enable 0x218, auxiliary flags 0x21C.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the master bit, both enable registers and both flag registers read as zero, and `irq_out` is zero.
- R2: A write to 0x218 stores the written bits ANDed with 0x7FF7. Bit 3 and bits 31:15 of 0x218 always read as zero.
- R3: A write to 0x21C clears each auxiliary flag bit that is written as 1 and is allowed by mask 0x7FF7. Flag bits written as 0 keep their value.
- R4: Bit 0 of the register at 0x208 is the master enable. It is the only stored bit there, and the other bits read as zero. When it is 1, `irq_out` equals (main enable AND main flags) OR (auxiliary enable AND auxiliary flags, zero-extended). When it is 0, `irq_out` is zero. `irq_out` follows the registers with no further pipeline stage. A write or strobe captured at a clock edge shows on `irq_out` right after that edge.
- R5: `aux_set[n]` sets auxiliary flag bit n and `aux_clr[n]` clears it. If a set strobe meets a hardware clear or a software clear of the same bit in the same cycle, the set wins.
- R6: The main enable at 0x210 is writable in all 32 bits. The main flags at 0x214 are cleared by writing 1 to a bit. `main_set` and `main_clr` act on the main flags with the same set-wins priority as in R5.
- R7: `bus_be[i]` enables writing byte i (bits 8i+7:8i). A write with `bus_be` = 4'b0011 changes only bits 15:0.
- R8: Reads of any offset other than the five listed return zero. Writes to those offsets change no register.
- R9: Auxiliary flag bits 3 and 15 never become 1, even when their set strobes are asserted.
- R10: With `HAS_AUX` = 0, offsets 0x218 and 0x21C read as zero, and the auxiliary sources never reach `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_be | input | 4 | Per-byte write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| main_set | input | 32 | Per-source set strobes, main flags |
| main_clr | input | 32 | Per-source clear strobes, main flags |
| aux_set | input | 16 | Per-source set strobes, auxiliary flags |
| aux_clr | input | 16 | Per-source clear strobes, auxiliary flags |
| irq_out | output | 32 | Level request vector to the core |

## Verification
The request merge is first tried with the auxiliary bank alone: the main enable is zero, so any leak of main flags or loss of auxiliary bits shows directly. It is then tried with both banks overlapping in the low half, which separates an OR merge from a replacement or an AND. It is also tried with the master bit cleared, which separates gating from passing through. Collisions of set strobes with hardware and software clears on the same bit show which action takes priority. Partial byte-strobe writes tell byte lanes apart. After the directed part, a long run of random bus traffic and sparse strobes is compared every clock against a behavioural model. A second instance built without the auxiliary bank shows that those sources are excluded there.

// File: rtl/irq2_pkg.sv
// Shared constants and types for the dual-bank interrupt controller.
// Assumes word-aligned register offsets inside a window of at least 1 KiB.
package irq2_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned AUX_W   = 16;
    localparam int unsigned BE_W    = DATA_W / 8;

    // writable / storable bits of the auxiliary bank
    localparam logic [AUX_W-1:0] AUX_WMASK = 16'h7FF7;

    // register offsets (byte addresses)
    localparam logic [31:0] OFS_MASTER  = 32'h0000_0208;
    localparam logic [31:0] OFS_MAIN_EN = 32'h0000_0210;
    localparam logic [31:0] OFS_MAIN_FL = 32'h0000_0214;
    localparam logic [31:0] OFS_AUX_EN  = 32'h0000_0218;
    localparam logic [31:0] OFS_AUX_FL  = 32'h0000_021C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASTER,
        SEL_MAIN_EN,
        SEL_MAIN_FL,
        SEL_AUX_EN,
        SEL_AUX_FL
    } reg_sel_e;
endpackage

// File: rtl/irq_reg_decode.sv
// Address decoder: maps a byte address to one register select.
// Address bits 1:0 are ignored; auxiliary offsets decode only when HAS_AUX.
module irq_reg_decode
    import irq2_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter bit          HAS_AUX = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int unsigned WA_W = ADDR_W - 2;

    logic [WA_W-1:0] word_addr;

    // word index of the access
    always_comb word_addr = addr[ADDR_W-1:2];

    // compare word index against each register offset
    always_comb begin
        sel = SEL_NONE;
        if (word_addr == OFS_MASTER[ADDR_W-1:2])
            sel = SEL_MASTER;
        else if (word_addr == OFS_MAIN_EN[ADDR_W-1:2])
            sel = SEL_MAIN_EN;
        else if (word_addr == OFS_MAIN_FL[ADDR_W-1:2])
            sel = SEL_MAIN_FL;
        else if (HAS_AUX && word_addr == OFS_AUX_EN[ADDR_W-1:2])
            sel = SEL_AUX_EN;
        else if (HAS_AUX && word_addr == OFS_AUX_FL[ADDR_W-1:2])
            sel = SEL_AUX_FL;
    end
endmodule

// File: rtl/irq_flag_bank.sv
// One enable/flag register pair with byte-lane writes.
// Enable: plain write under mask. Flags: write-one-to-clear by software,
// per-bit hardware set/clear strobes, set has priority over any clear.
// Bits outside WMASK are never stored. Assumes WIDTH is a multiple of 8.
module irq_flag_bank #(
    parameter int unsigned     WIDTH = 32,
    parameter logic [WIDTH-1:0] WMASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_wr,
    input  logic               fl_wr,
    input  logic [WIDTH-1:0]   wdata,
    input  logic [WIDTH/8-1:0] be,
    input  logic [WIDTH-1:0]   hw_set,
    input  logic [WIDTH-1:0]   hw_clr,
    output logic [WIDTH-1:0]   en_q,
    output logic [WIDTH-1:0]   fl_q,
    output logic [WIDTH-1:0]   req
);
    localparam int unsigned NBYTE = WIDTH / 8;

    logic [WIDTH-1:0] lane_mask;
    logic [WIDTH-1:0] wr_bits;
    logic [WIDTH-1:0] sw_clr;
    logic [WIDTH-1:0] en_d;
    logic [WIDTH-1:0] fl_d;

    // expand byte enables into a bit mask
    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        assign lane_mask[b*8 +: 8] = {8{be[b]}};
    end

    // written bits restricted to enabled lanes and storable bits
    always_comb wr_bits = wdata & lane_mask & WMASK;

    // software clear vector for the flag register
    always_comb sw_clr = fl_wr ? wr_bits : '0;

    // next enable value: replace enabled lanes only
    always_comb begin
        en_d = en_q;
        if (en_wr)
            en_d = ((en_q & ~lane_mask) | wr_bits) & WMASK;
    end

    // next flag value: clears first, then sets override
    always_comb fl_d = ((fl_q & ~sw_clr & ~hw_clr) | hw_set) & WMASK;

    // register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            fl_q <= '0;
        end else begin
            en_q <= en_d;
            fl_q <= fl_d;
        end
    end

    // pending and enabled sources
    always_comb req = en_q & fl_q;
endmodule

// File: rtl/dual_irq_ctrl.sv
// Dual-bank interrupt controller top: master enable, main 32-bit bank,
// optional 16-bit auxiliary bank (HAS_AUX), register read mux and the
// merged level request. Request is combinational from registers.
module dual_irq_ctrl
    import irq2_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter bit          HAS_AUX = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       main_set,
    input  logic [31:0]       main_clr,
    input  logic [15:0]       aux_set,
    input  logic [15:0]       aux_clr,
    output logic [31:0]       irq_out
);
    localparam int unsigned PAD_W = DATA_W - AUX_W;

    reg_sel_e          sel;
    logic              wr_go;
    logic              rd_go;
    logic              master_q;
    logic [DATA_W-1:0] m_en;
    logic [DATA_W-1:0] m_flg;
    logic [DATA_W-1:0] m_req;
    logic [AUX_W-1:0]  a_en;
    logic [AUX_W-1:0]  a_flg;
    logic [AUX_W-1:0]  a_req;

    irq_reg_decode #(.ADDR_W(ADDR_W), .HAS_AUX(HAS_AUX)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    // qualify the bus access
    always_comb begin
        wr_go = bus_sel && bus_wr;
        rd_go = bus_sel && !bus_wr;
    end

    // master enable: only byte 0, bit 0 is stored
    always_ff @(posedge clk) begin
        if (!rst_n)
            master_q <= 1'b0;
        else if (wr_go && sel == SEL_MASTER && bus_be[0])
            master_q <= bus_wdata[0];
    end

    irq_flag_bank #(.WIDTH(DATA_W), .WMASK({DATA_W{1'b1}})) u_main (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_wr  (wr_go && sel == SEL_MAIN_EN),
        .fl_wr  (wr_go && sel == SEL_MAIN_FL),
        .wdata  (bus_wdata),
        .be     (bus_be),
        .hw_set (main_set),
        .hw_clr (main_clr),
        .en_q   (m_en),
        .fl_q   (m_flg),
        .req    (m_req)
    );

    // auxiliary bank only for the processor that owns those sources
    if (HAS_AUX) begin : g_aux
        irq_flag_bank #(.WIDTH(AUX_W), .WMASK(AUX_WMASK)) u_aux (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_wr  (wr_go && sel == SEL_AUX_EN),
            .fl_wr  (wr_go && sel == SEL_AUX_FL),
            .wdata  (bus_wdata[AUX_W-1:0]),
            .be     (bus_be[AUX_W/8-1:0]),
            .hw_set (aux_set),
            .hw_clr (aux_clr),
            .en_q   (a_en),
            .fl_q   (a_flg),
            .req    (a_req)
        );
    end else begin : g_no_aux
        assign a_en  = '0;
        assign a_flg = '0;
        assign a_req = '0;
    end

    // read data mux, zero outside reads and for unknown offsets
    always_comb begin
        bus_rdata = '0;
        if (rd_go) begin
            unique case (sel)
                SEL_MASTER:  bus_rdata = {{(DATA_W-1){1'b0}}, master_q};
                SEL_MAIN_EN: bus_rdata = m_en;
                SEL_MAIN_FL: bus_rdata = m_flg;
                SEL_AUX_EN:  bus_rdata = {{PAD_W{1'b0}}, a_en};
                SEL_AUX_FL:  bus_rdata = {{PAD_W{1'b0}}, a_flg};
                default:     bus_rdata = '0;
            endcase
        end
    end

    // merged request gated by the master enable
    always_comb irq_out = master_q ? (m_req | {{PAD_W{1'b0}}, a_req}) : '0;
endmodule

// File: rtl/dual_irq_ctrl_chk.sv
// Checker for dual_irq_ctrl, attached by bind. Observes ports and the
// register state; assumes the synchronous active-low reset of the top.
module dual_irq_ctrl_chk
    import irq2_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter bit          HAS_AUX = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       main_set,
    input logic [15:0]       aux_set,
    input logic [31:0]       irq_out,
    input logic              master_q,
    input logic [31:0]       m_en,
    input logic [31:0]       m_flg,
    input logic [15:0]       a_flg
);
    logic [ADDR_W-3:0] wa;
    logic              known;
    logic              rd;

    // observation helpers
    always_comb begin
        wa    = bus_addr[ADDR_W-1:2];
        rd    = bus_sel && !bus_wr;
        known = (wa == OFS_MASTER[ADDR_W-1:2]) || (wa == OFS_MAIN_EN[ADDR_W-1:2]) ||
                (wa == OFS_MAIN_FL[ADDR_W-1:2]) || (wa == OFS_AUX_EN[ADDR_W-1:2]) ||
                (wa == OFS_AUX_FL[ADDR_W-1:2]);
    end

    assert_gate_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !master_q |-> irq_out == 32'h0);

    assert_aux_en_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && wa == OFS_AUX_EN[ADDR_W-1:2]) |-> (bus_rdata & ~{16'h0, AUX_WMASK}) == 32'h0);

    assert_aux_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_AUX && |(aux_set & AUX_WMASK)) |=>
        ((a_flg & $past(aux_set & AUX_WMASK)) == $past(aux_set & AUX_WMASK)));

    assert_aux_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((a_flg & ~$past(a_flg) & ~$past(aux_set)) == 16'h0));

    assert_main_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|main_set) |=> ((m_flg & $past(main_set)) == $past(main_set)));

    assert_lane_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_be == 4'h0) |=> $stable(m_en));

    assert_unknown_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !known) |-> bus_rdata == 32'h0);

    assert_aux_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        a_flg[3] == 1'b0 && a_flg[15] == 1'b0);
endmodule

bind dual_irq_ctrl dual_irq_ctrl_chk #(.ADDR_W(ADDR_W), .HAS_AUX(HAS_AUX)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata),
    .main_set  (main_set),
    .aux_set   (aux_set),
    .irq_out   (irq_out),
    .master_q  (master_q),
    .m_en      (m_en),
    .m_flg     (m_flg),
    .a_flg     (a_flg)
);

// File: tb/test_dual_irq_ctrl.sv
`timescale 1ns/100ps
module test_dual_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] main_set = '0;
    logic [31:0] main_clr = '0;
    logic [15:0] aux_set = '0;
    logic [15:0] aux_clr = '0;
    logic [31:0] irq_out;
    logic [31:0] prim_rdata;
    logic [31:0] prim_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] r_master, r_men, r_mfl, r_aen, r_afl;

    always #2.5 clk = ~clk;

    dual_irq_ctrl #(.ADDR_W(12), .HAS_AUX(1'b1)) i_dual_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .main_set(main_set), .main_clr(main_clr),
        .aux_set(aux_set), .aux_clr(aux_clr), .irq_out(irq_out)
    );

    dual_irq_ctrl #(.ADDR_W(12), .HAS_AUX(1'b0)) i_dual_irq_ctrl_prim (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(prim_rdata), .main_set(main_set), .main_clr(main_clr),
        .aux_set(aux_set), .aux_clr(aux_clr), .irq_out(prim_irq)
    );

    function automatic logic [31:0] lanes(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case ({a[11:2], 2'b00})
            12'h208: return r_master & 32'h1;
            12'h210: return r_men;
            12'h214: return r_mfl;
            12'h218: return r_aen;
            12'h21C: return r_afl;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] model_irq();
        if (r_master[0]) return (r_men & r_mfl) | (r_aen & r_afl);
        return 32'h0;
    endfunction

    // behavioural model, one step per clock
    always @(posedge clk) begin
        logic [31:0] bm, wb, swc;
        logic [11:0] wa;
        if (!rst_n) begin
            r_master = 0; r_men = 0; r_mfl = 0; r_aen = 0; r_afl = 0;
        end else begin
            bm = lanes(bus_be);
            wb = bus_wdata & bm;
            wa = {bus_addr[11:2], 2'b00};
            swc = 0;
            if (bus_sel && bus_wr && wa == 12'h208 && bus_be[0]) r_master = {31'h0, bus_wdata[0]};
            if (bus_sel && bus_wr && wa == 12'h210) r_men = (r_men & ~bm) | wb;
            if (bus_sel && bus_wr && wa == 12'h214) swc = wb;
            r_mfl = (r_mfl & ~swc & ~main_clr) | main_set;
            swc = 0;
            if (bus_sel && bus_wr && wa == 12'h218) r_aen = ((r_aen & ~bm) | wb) & 32'h7FF7;
            if (bus_sel && bus_wr && wa == 12'h21C) swc = wb;
            r_afl = ((r_afl & ~swc & ~{16'h0, aux_clr}) | {16'h0, aux_set}) & 32'h7FF7;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every clock: compare request and read data against the model (R4)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 irq per cycle", irq_out, model_irq());
            if (bus_sel && !bus_wr) check("R8 rdata per cycle", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        cyc();
        bus_sel = 0; bus_wr = 0; bus_be = 0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        bus_sel = 0;
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1: reset state
        rd("R1 master", 12'h208, 0);
        rd("R1 main en", 12'h210, 0);
        rd("R1 main fl", 12'h214, 0);
        rd("R1 aux en", 12'h218, 0);
        rd("R1 aux fl", 12'h21C, 0);
        check("R1 irq", irq_out, 0);
        // R4: master bit only bit 0 stored
        wr(12'h208, 4'hF, 32'hFFFF_FFFF);
        rd("R4 master readback", 12'h208, 32'h1);
        // R2: aux enable mask
        wr(12'h218, 4'hF, 32'hFFFF_FFFF);
        rd("R2 aux en mask", 12'h218, 32'h0000_7FF7);
        // R9 / R4: set all aux sources, only auxiliary bank reaches irq
        aux_set = 16'hFFFF; cyc(); aux_set = 0;
        rd("R9 aux fl reserved", 12'h21C, 32'h0000_7FF7);
        check("R4 aux only irq", irq_out, 32'h0000_7FF7);
        // R3: write-one-to-clear
        wr(12'h21C, 4'hF, 32'h0000_0101);
        rd("R3 aux w1c", 12'h21C, 32'h0000_7EF6);
        // R5: hardware clear, then collisions
        aux_clr = 16'h0020; cyc(); aux_clr = 0;
        rd("R5 hw clear", 12'h21C, 32'h0000_7ED6);
        aux_set = 16'h0010; wr(12'h21C, 4'hF, 32'h0000_0010); aux_set = 0;
        rd("R5 set beats sw clear", 12'h21C, 32'h0000_7ED6);
        aux_set = 16'h0040; aux_clr = 16'h0040; cyc(); aux_set = 0; aux_clr = 0;
        rd("R5 set beats hw clear", 12'h21C, 32'h0000_7ED6);
        // R7: byte lanes on main enable
        wr(12'h210, 4'b0011, 32'hAAAA_5555);
        rd("R7 low half only", 12'h210, 32'h0000_5555);
        wr(12'h210, 4'b1100, 32'h1234_5678);
        rd("R7 high half only", 12'h210, 32'h1234_5555);
        // R6: main flags and merge with aux bank
        main_set = 32'hFFFF_FFFF; cyc(); main_set = 0;
        check("R4 merged irq", irq_out, 32'h1234_7FD7);
        wr(12'h214, 4'hF, 32'hFFFF_0000);
        rd("R6 main w1c", 12'h214, 32'h0000_FFFF);
        main_set = 32'h0000_0001; main_clr = 32'h0000_0003; cyc(); main_set = 0; main_clr = 0;
        rd("R6 main set beats clr", 12'h214, 32'h0000_FFFD);
        // R10: instance without the auxiliary bank
        bus_sel = 1; bus_wr = 0; bus_addr = 12'h218; #1;
        check("R10 prim aux en reads zero", prim_rdata, 0);
        bus_sel = 0;
        check("R10 prim irq excludes aux", prim_irq, 32'h0000_5555);
        // R8: undefined offsets
        wr(12'h20C, 4'hF, 32'hFFFF_FFFF);
        wr(12'h300, 4'hF, 32'hFFFF_FFFF);
        rd("R8 undefined 20C", 12'h20C, 0);
        rd("R8 undefined 300", 12'h300, 0);
        rd("R8 main en untouched", 12'h210, 32'h1234_5555);
        // R4: master off
        wr(12'h208, 4'hF, 32'hFFFF_FFFE);
        rd("R4 master cleared", 12'h208, 0);
        check("R4 gated irq", irq_out, 0);
        wr(12'h208, 4'h1, 32'h1);
        // random traffic compared every clock against the model
        for (int i = 0; i < 400; i++) begin
            logic [11:0] addrs [7];
            addrs = '{12'h208, 12'h20C, 12'h210, 12'h214, 12'h218, 12'h21C, 12'h300};
            bus_sel   = $urandom_range(0, 1);
            bus_wr    = $urandom_range(0, 1);
            bus_addr  = addrs[$urandom_range(0, 6)] | 12'($urandom_range(0, 3));
            bus_be    = 4'($urandom);
            bus_wdata = $urandom;
            main_set  = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : 0;
            main_clr  = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : 0;
            aux_set   = ($urandom_range(0, 2) == 0) ? (16'h1 << $urandom_range(0, 15)) : 0;
            aux_clr   = ($urandom_range(0, 2) == 0) ? (16'h1 << $urandom_range(0, 15)) : 0;
            cyc();
        end
        bus_sel = 0; main_set = 0; main_clr = 0; aux_set = 0; aux_clr = 0;
        cyc();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule